// File: doc/BRIEF.md
# UART Transmit Engine with Sync Break Generation

This block serializes one character at a time onto a single asynchronous serial output line. A request places a character in a holding register. On the next bit-rate strobe from outside the block, a frame is built and copied into a shift register. The shift register then advances one position on every following strobe. A frame consists of:

- one low start bit;
- seven or eight data bits, sent in either bit order;
- an optional parity bit;
- one or two high stop bits.

A separate command replaces the data frame with a synchronization break. The break holds the line at its dominant low level for a selectable 13 to 20 bit times and then releases it to idle. A polarity input inverts the whole output: idle, start, data, parity, stop and break levels all flip.

A one-cycle completion pulse marks the moment the last bit of a frame or break has finished and the line is back at idle. The busy flag falls in that same cycle. The block holds no queue. It takes a new request only while it is neither shifting nor holding a request that has not yet been loaded, and it ignores every request outside that window.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, and whenever busy is low, the output sits at the idle level: high when cfg_invert is 0 and low when it is 1. In the reset state, busy and done are both 0.
- R2: A data frame is a single low start bit, then the data bits, then the parity bit if one is enabled, then the stop bits at high level. Each bit lasts exactly one bit_tick interval, and the line changes only in the cycle after a bit_tick.
- R3: With cfg_len8=1 the frame carries wr_data[7:0]. With cfg_len8=0 it carries wr_data[6:0], and wr_data[7] is not sent.
- R4: cfg_par selects the parity bit. 00 sends no parity bit. 01 sends a bit that makes the number of ones in the data plus parity even. 10 makes that count odd. 11 always sends 0.
- R5: cfg_stop2=0 sends one stop bit and cfg_stop2=1 sends two.
- R6: cfg_msb_first=0 sends data bit 0 first. cfg_msb_first=1 sends the highest data bit in use first: bit 7 in 8-bit mode, bit 6 in 7-bit mode.
- R7: cfg_invert=1 inverts every level driven on tx_out, including idle and break.
- R8: brk_req with brk_len=k holds the line at the dominant low level for 13+k bit times and then returns it to idle. If brk_req and wr_en arrive in the same accepted cycle, the break is sent and the character is dropped.
- R9: A request is accepted only when busy is low and no request is waiting. The start bit, together with the rise of busy, appears in the cycle after the first bit_tick that follows acceptance.
- R10: done pulses high for exactly one cycle. It rises in the same cycle that the line returns to idle after the last bit, and busy falls in that cycle too.
- R11: wr_en or brk_req asserted while busy is high is ignored. No further frame and no further done pulse follow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe, one per bit time |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_par | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 zero |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_msb_first | input | 1 | 1: highest data bit first |
| cfg_invert | input | 1 | Inverts the output level |
| wr_en | input | 1 | Character write request |
| wr_data | input | 8 | Character to send |
| brk_req | input | 1 | Sync break request |
| brk_len | input | 3 | Break length selector, 13+k bit times |
| tx_out | output | 1 | Serial output line |
| busy | output | 1 | A frame or break is being shifted out |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that bit_tick is a single-cycle strobe, that consecutive strobes are several clocks apart, and that cfg_invert does not change while a frame is being sent. The bench produces bit_tick from a free-running divider with a fixed period of eight clocks. It changes configuration only while busy is low, and it drives every input on the falling clock edge. The format inputs are read only when a frame is loaded, so the bench holds them from the request until the start bit has appeared.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W    = 8;
    localparam int MIN_BRK   = 13;
    localparam int BRK_SEL_W = 3;
    localparam int MAX_STOP  = 2;
    localparam int DFRAME_W  = 1 + DATA_W + 1 + MAX_STOP;
    localparam int BFRAME_W  = MIN_BRK + (1 << BRK_SEL_W) - 1;
    localparam int FRAME_W   = (DFRAME_W > BFRAME_W) ? DFRAME_W : BFRAME_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ZERO = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic      len8;
        par_mode_e par;
        logic      stop2;
        logic      msb_first;
    } fmt_t;

    typedef struct packed {
        logic                 is_break;
        logic [DATA_W-1:0]    data;
        logic [BRK_SEL_W-1:0] brk_sel;
    } req_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
    } frame_t;

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = d[DATA_W-1-i];
        end
        return r;
    endfunction

    function automatic logic par_bit(input par_mode_e m, input logic [DATA_W-1:0] d);
        logic p;
        case (m)
            PAR_EVEN: p = ^d;
            PAR_ODD:  p = ~(^d);
            default:  p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  req_t   req,
    input  fmt_t   fmt,
    output frame_t frame
);

    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] ordered;
    int                nd;
    logic              has_par;

    always_comb begin
        nd      = fmt.len8 ? DATA_W : DATA_W - 1;
        masked  = req.data;
        if (!fmt.len8) begin
            masked[DATA_W-1] = 1'b0;
        end
        ordered = fmt.msb_first ? (bit_rev(masked) >> (DATA_W - nd)) : masked;
        has_par = (fmt.par != PAR_NONE);

        frame.bits = '1;
        frame.len  = '0;
        if (req.is_break) begin
            frame.bits = '0;
            frame.len  = CNT_W'(MIN_BRK) + CNT_W'(req.brk_sel);
        end else begin
            frame.bits[0] = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (i < nd) begin
                    frame.bits[1+i] = ordered[i];
                end
            end
            for (int j = 0; j < FRAME_W; j++) begin
                if (has_par && (j == 1 + nd)) begin
                    frame.bits[j] = par_bit(fmt.par, masked);
                end
            end
            frame.len = CNT_W'(1 + nd) + CNT_W'(has_par) + (fmt.stop2 ? CNT_W'(2) : CNT_W'(1));
        end
    end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 brk_req,
    input  logic [BRK_SEL_W-1:0] brk_sel,
    input  logic                 busy,
    input  logic                 load,
    output logic                 pending,
    output req_t                 req
);

    logic accept;

    assign accept = !busy && !pending && (wr_en || brk_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            req     <= '0;
        end else if (load) begin
            pending <= 1'b0;
        end else if (accept) begin
            pending      <= 1'b1;
            req.is_break <= brk_req;
            req.data     <= wr_data;
            req.brk_sel  <= brk_sel;
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_tick,
    input  logic   pending,
    input  frame_t frame,
    output logic   load,
    output logic   busy,
    output logic   line_raw,
    output logic   done
);

    typedef enum logic {SH_IDLE, SH_SEND} sh_state_e;

    sh_state_e          st;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;

    assign load = bit_tick && pending && (st == SH_IDLE);
    assign busy = (st == SH_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SH_IDLE;
            shreg    <= '0;
            left     <= '0;
            line_raw <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (load) begin
                        st       <= SH_SEND;
                        line_raw <= frame.bits[0];
                        shreg    <= frame.bits >> 1;
                        left     <= frame.len - CNT_W'(1);
                    end
                end
                default: begin
                    if (bit_tick) begin
                        if (left == '0) begin
                            st       <= SH_IDLE;
                            line_raw <= 1'b1;
                            done     <= 1'b1;
                        end else begin
                            line_raw <= shreg[0];
                            shreg    <= shreg >> 1;
                            left     <= left - CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_tick,
    input  logic                 cfg_len8,
    input  logic [1:0]           cfg_par,
    input  logic                 cfg_stop2,
    input  logic                 cfg_msb_first,
    input  logic                 cfg_invert,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 brk_req,
    input  logic [BRK_SEL_W-1:0] brk_len,
    output logic                 tx_out,
    output logic                 busy,
    output logic                 done
);

    fmt_t   fmt;
    req_t   req;
    frame_t frame;
    logic   pending;
    logic   load;
    logic   line_raw;

    assign fmt.len8      = cfg_len8;
    assign fmt.par       = par_mode_e'(cfg_par);
    assign fmt.stop2     = cfg_stop2;
    assign fmt.msb_first = cfg_msb_first;

    uart_tx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .brk_req (brk_req),
        .brk_sel (brk_len),
        .busy    (busy),
        .load    (load),
        .pending (pending),
        .req     (req)
    );

    uart_tx_framer u_framer (
        .req   (req),
        .fmt   (fmt),
        .frame (frame)
    );

    uart_tx_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .pending  (pending),
        .frame    (frame),
        .load     (load),
        .busy     (busy),
        .line_raw (line_raw),
        .done     (done)
    );

    assign tx_out = line_raw ^ cfg_invert;

endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic busy,
    input logic done,
    input logic tx_out,
    input logic cfg_invert,
    input logic line_raw
);

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tx_out == !cfg_invert)); // R1

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_tick) |-> $stable(line_raw)); // R2

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !line_raw); // R2

    AST_BUSY_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bit_tick)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && line_raw)); // R10

endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .busy       (busy),
    .done       (done),
    .tx_out     (tx_out),
    .cfg_invert (cfg_invert),
    .line_raw   (line_raw)
);

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;

    localparam int TICK = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       cfg_len8 = 1'b1;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_req = 1'b0;
    logic [2:0] brk_len = 3'd0;
    logic       tx_out;
    logic       busy;
    logic       done;
    logic       raw;

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int tick_div = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uart_tx_brk u_uart_tx_brk (
        .clk           (clk),
        .rst           (rst),
        .bit_tick      (bit_tick),
        .cfg_len8      (cfg_len8),
        .cfg_par       (cfg_par),
        .cfg_stop2     (cfg_stop2),
        .cfg_msb_first (cfg_msb_first),
        .cfg_invert    (cfg_invert),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .brk_req       (brk_req),
        .brk_len       (brk_len),
        .tx_out        (tx_out),
        .busy          (busy),
        .done          (done)
    );

    assign raw = tx_out ^ cfg_invert;

    always @(negedge clk) begin
        tick_div = (tick_div == TICK - 1) ? 0 : tick_div + 1;
        bit_tick <= (tick_div == 0);
        if (!rst && done) done_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic exp_frame(input logic [7:0] d, input logic l8, input logic [1:0] pm,
                             input logic s2, input logic msb,
                             output logic [19:0] bits, output int n);
        int nd;
        int ones;
        nd   = l8 ? 8 : 7;
        ones = 0;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            ones += int'(d[i]);
            bits[1+i] = msb ? d[nd-1-i] : d[i];
        end
        n = 1 + nd;
        if (pm != 2'b00) begin
            bits[n] = (pm == 2'b01) ? logic'(ones % 2) :
                      (pm == 2'b10) ? logic'(1 - ones % 2) : 1'b0;
            n++;
        end
        n += s2 ? 2 : 1;
    endtask

    // waits for the start edge, returns latency in clocks, then samples at bit centres
    task automatic rx_bits(input int n, output logic [19:0] got, output int lat);
        got = '1;
        lat = 0;
        while (raw !== 1'b0 && lat < 40 * TICK) begin
            @(negedge clk);
            lat++;
        end
        repeat (TICK / 2) @(negedge clk);
        got[0] = raw;
        chk("R9 busy during frame", 32'(busy), 32'd1);
        for (int i = 1; i < n; i++) begin
            repeat (TICK) @(negedge clk);
            got[i] = raw;
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic l8, input logic [1:0] pm,
                              input logic s2, input logic msb, input logic inv,
                              input bit poke_busy);
        logic [19:0] exp;
        logic [19:0] got;
        logic [19:0] mask;
        int          n;
        int          lat;
        int          d0;
        int          act;
        cfg_len8 = l8; cfg_par = pm; cfg_stop2 = s2; cfg_msb_first = msb; cfg_invert = inv;
        @(negedge clk);
        chk("R1 idle before request", 32'(tx_out), 32'(!inv));
        exp_frame(d, l8, pm, s2, msb, exp, n);
        d0 = done_cnt;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        rx_bits(n, got, lat);
        if (poke_busy) begin
            wr_en = 1'b1; brk_req = 1'b1; wr_data = ~d;
            @(negedge clk);
            wr_en = 1'b0; brk_req = 1'b0;
        end
        mask = 20'((32'd1 << n) - 1);
        chk($sformatf("R2 R3 R4 R5 R6 R7 frame d=%0h len8=%0d par=%0d stop2=%0d msb=%0d inv=%0d",
                      d, l8, pm, s2, msb, inv), 32'(got & mask), 32'(exp & mask));
        chk("R9 start latency within one tick", 32'(lat <= TICK + 1), 32'd1);
        repeat (TICK) @(negedge clk);
        chk("R10 idle and not busy after last bit", {30'd0, raw, busy}, 32'd2);
        chk("R10 one done pulse per frame", 32'(done_cnt - d0), 32'd1);
        if (poke_busy) begin
            act = 0;
            repeat (25 * TICK) begin
                @(negedge clk);
                if (raw !== 1'b1) act++;
            end
            chk("R11 request during busy ignored (line)", 32'(act), 32'd0);
            chk("R11 request during busy ignored (done)", 32'(done_cnt - d0), 32'd1);
        end
    endtask

    task automatic send_break(input logic [2:0] k, input logic inv);
        int lat;
        int low;
        int act;
        int d0;
        cfg_invert = inv;
        @(negedge clk);
        d0 = done_cnt;
        brk_req = 1'b1; brk_len = k; wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        brk_req = 1'b0; wr_en = 1'b0;
        lat = 0;
        while (raw !== 1'b0 && lat < 40 * TICK) begin
            @(negedge clk);
            lat++;
        end
        repeat (TICK / 2) @(negedge clk);
        low = 0;
        while (raw === 1'b0 && low < 30) begin
            low++;
            repeat (TICK) @(negedge clk);
        end
        chk($sformatf("R8 R7 break length k=%0d inv=%0d", k, inv), 32'(low), 32'(13 + int'(k)));
        chk("R10 done after break", 32'(done_cnt - d0), 32'd1);
        act = 0;
        repeat (20 * TICK) begin
            @(negedge clk);
            if (raw !== 1'b1) act++;
        end
        chk("R8 write with break dropped", 32'(act), 32'd0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset idle line", 32'(tx_out), 32'd1);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        cfg_invert = 1'b1;
        @(negedge clk);
        chk("R7 inverted idle level", 32'(tx_out), 32'd0);
        cfg_invert = 1'b0;

        for (int c = 0; c < 64; c++) begin
            for (int v = 0; v < 3; v++) begin
                logic [7:0] d;
                d = (v == 0) ? 8'hA5 : (v == 1) ? 8'(8'h3C + c) : 8'(8'h81 ^ (c * 7));
                send_frame(d, logic'(c[0]), c[2:1], logic'(c[3]), logic'(c[4]), logic'(c[5]), 1'b0);
            end
        end

        // R3: bit 7 must not reach the line in 7-bit mode
        send_frame(8'hFF, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h80, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);

        // R11: requests while busy
        send_frame(8'h5A, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
        send_frame(8'hC3, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1);

        for (int k = 0; k < 8; k++) begin
            send_break(3'(k), logic'(k[0]));
        end

        summary();
    end

endmodule